// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers eight interrupt sources into a sticky pending register. It asks a CPU sequencer for service while any pending source is eligible, and it reports the index of the winning source. Source 0 is the most urgent, and higher indices rank lower. When the sequencer acknowledges the request, the winning pending bit is cleared. At the same moment the live processor flags are copied into a shadow register and the interrupt-active bit is set.

The live flags are held here. A return-from-interrupt copies the shadow back into the live flags, and a clear strobe drops only the interrupt-active bit. The sequencer loads new flag values through a write strobe.

Four build-time options change the behaviour:
- Source 0 can be made immune to its mask.
- New service can be blocked while the interrupt-active bit is set.
- A return can restore only the low flag nibble.
- The interrupt-active bit can come out of reset already set.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Each cycle, new requests are `(irq_hw_i | irq_sw_i) & mask`. The mask register is loaded from `mask_data_i` on the edge where `mask_wr_i` is high and takes effect from the next edge. A source whose mask bit is 0 never sets its pending bit.
- R2: A pending bit stays set until an accepted acknowledge clears it. A new request for the same source in the acknowledge cycle keeps the bit set.
- R3: `req_o` is high when any pending bit is set and the wait flag is clear. `vec_o` is the lowest index among the set pending bits, so bit 0 has the highest priority.
- R4: An acknowledge with `req_o` high clears pending bit `vec_o` at that edge. An acknowledge with `req_o` low changes neither the pending bits nor the flags.
- R5: An accepted acknowledge copies the live flags into the shadow register and sets flag bit 3 (the interrupt-active bit) in the live flags.
- R6: `rti_i` loads the live flags from the shadow. With `RTI_LOW_ONLY`=1, only bits 3:0 are loaded and bits 7:4 keep their live values.
- R7: `clr_ibit_i` clears flag bit 3 and leaves the other flag bits unchanged.
- R8: `flag_wr_i` loads the live flags from `flag_data_i`.
- R9: With `NMI_EN`=1, source 0 ignores mask bit 0. With `NMI_EN`=0 (the default), source 0 is masked like the other sources.
- R10: With `SEQ_EN`=1, a wait flag is registered from flag bit 3 every cycle, and while it is set `req_o` stays low for every source, source 0 included. With `SEQ_EN`=0, the wait flag stays 0 and service may nest.
- R11: Reset clears the pending bits, the mask, the shadow and the wait flag. The live flags reset to 0, or to 0x08 when `I_AT_RESET`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_hw_i | input | 8 | Hardware interrupt lines |
| irq_sw_i | input | 8 | Software interrupt strobes |
| mask_wr_i | input | 1 | Mask register load strobe |
| mask_data_i | input | 8 | New mask value |
| ack_i | input | 1 | Sequencer accepts the current request |
| rti_i | input | 1 | Return-from-interrupt strobe |
| clr_ibit_i | input | 1 | Clear interrupt-active flag strobe |
| flag_wr_i | input | 1 | Live flag load strobe |
| flag_data_i | input | 8 | Live flag load value |
| req_o | output | 1 | Service request |
| vec_o | output | 3 | Index of the winning pending source |
| pend_o | output | 8 | Pending register |
| flags_o | output | 8 | Live processor flags |

## Verification
The flag assertions take for granted that the sequencer raises at most one of acknowledge, return, clear and flag write in any one cycle. The internal order between these strobes exists only as a fallback. The stimulus pulses each strobe alone for a single cycle and never overlaps two of them. Hardware lines and software strobes may arrive together, or together with an acknowledge. The bench drives a default build and a build with all options enabled from the same inputs, so that each option can be compared against its absence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    F_HOLD,
    F_LOAD,
    F_CLRI,
    F_RTI,
    F_ENTER
  } flag_op_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_IRQ  = 8,
  parameter bit NMI_EN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] hw_i,
  input  logic [N_IRQ-1:0] sw_i,
  input  logic             mask_wr_i,
  input  logic [N_IRQ-1:0] mask_data_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] mask_q, eff_mask, new_req, pend_q;

  always_comb begin
    eff_mask = mask_q;
    if (NMI_EN) eff_mask[0] = 1'b1;
    new_req = (hw_i | sw_i) & eff_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_wr_i) mask_q <= mask_data_i;
      // a fresh request beats the clear of the serviced bit
      pend_q <= (pend_q & ~clr_i) | new_req;
    end
  end

  assign pend_o = pend_q;

  p_masked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((pend_q & ~$past(pend_q) & ~$past(eff_mask)) == '0));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_IRQ = 8,
  localparam int VW   = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] pend_i,
  output logic             any_o,
  output logic [VW-1:0]    vec_o,
  output logic [N_IRQ-1:0] grant_o
);
  logic [N_IRQ:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_chain
    assign grant_o[g]  = pend_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | pend_i[g];
  end

  assign any_o = seen[N_IRQ];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (grant_o[i]) vec_o = vec_o | VW'(i);
  end

  logic [N_IRQ-1:0] below_m;
  always_comb begin
    below_m = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (i < int'(vec_o)) below_m[i] = 1'b1;
  end

  p_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (pend_i[vec_o] && ((pend_i & below_m) == '0)));
endmodule

// File: rtl/irq_flag_keep.sv
module irq_flag_keep
  import irq_pkg::*;
#(
  parameter int FW           = 8,
  parameter int I_BIT        = 3,
  parameter int LOW_W        = 4,
  parameter bit SEQ_EN       = 1'b0,
  parameter bit RTI_LOW_ONLY = 1'b0,
  parameter bit I_AT_RESET   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enter_i,
  input  logic          rti_i,
  input  logic          clri_i,
  input  logic          wr_i,
  input  logic [FW-1:0] wdata_i,
  output logic [FW-1:0] flags_o,
  output logic          wait_o
);
  localparam logic [FW-1:0] RST_FLAGS = I_AT_RESET ? (FW'(1) << I_BIT) : '0;

  flag_op_e      op;
  logic [FW-1:0] flags_q, shadow_q, restored;
  logic          wait_q;

  always_comb begin
    if      (enter_i) op = F_ENTER;
    else if (rti_i)   op = F_RTI;
    else if (clri_i)  op = F_CLRI;
    else if (wr_i)    op = F_LOAD;
    else              op = F_HOLD;
  end

  if (RTI_LOW_ONLY) begin : g_part
    assign restored = {flags_q[FW-1:LOW_W], shadow_q[LOW_W-1:0]};
  end else begin : g_full
    assign restored = shadow_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= RST_FLAGS;
      shadow_q <= '0;
      wait_q   <= 1'b0;
    end else begin
      wait_q <= SEQ_EN ? flags_q[I_BIT] : 1'b0;
      unique case (op)
        F_ENTER: begin
          shadow_q       <= flags_q;
          flags_q[I_BIT] <= 1'b1;
        end
        F_RTI:   flags_q        <= restored;
        F_CLRI:  flags_q[I_BIT] <= 1'b0;
        F_LOAD:  flags_q        <= wdata_i;
        default: ;
      endcase
    end
  end

  assign flags_o = flags_q;
  assign wait_o  = wait_q;

  p_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (flags_q[I_BIT] && shadow_q == $past(flags_q)));

  p_clri_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clri_i && !enter_i && !rti_i) |=> !flags_q[I_BIT]);

  p_rti_gp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RTI_LOW_ONLY && rti_i && !enter_i) |=>
      flags_q[FW-1:LOW_W] == $past(flags_q[FW-1:LOW_W]));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int N_IRQ        = 8,
  parameter int FW           = 8,
  parameter int I_BIT        = 3,
  parameter int LOW_W        = 4,
  parameter bit NMI_EN       = 1'b0,
  parameter bit SEQ_EN       = 1'b0,
  parameter bit RTI_LOW_ONLY = 1'b0,
  parameter bit I_AT_RESET   = 1'b0,
  localparam int VW          = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_hw_i,
  input  logic [N_IRQ-1:0] irq_sw_i,
  input  logic             mask_wr_i,
  input  logic [N_IRQ-1:0] mask_data_i,
  input  logic             ack_i,
  input  logic             rti_i,
  input  logic             clr_ibit_i,
  input  logic             flag_wr_i,
  input  logic [FW-1:0]    flag_data_i,
  output logic             req_o,
  output logic [VW-1:0]    vec_o,
  output logic [N_IRQ-1:0] pend_o,
  output logic [FW-1:0]    flags_o
);
  logic [N_IRQ-1:0] pend, grant, clr_vec;
  logic             any_pend, wait_f, take;

  irq_pend_reg #(.N_IRQ(N_IRQ), .NMI_EN(NMI_EN)) u_pend (
    .clk_i, .rst_ni,
    .hw_i(irq_hw_i), .sw_i(irq_sw_i),
    .mask_wr_i, .mask_data_i,
    .clr_i(clr_vec), .pend_o(pend)
  );

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
    .clk_i, .rst_ni,
    .pend_i(pend), .any_o(any_pend), .vec_o(vec_o), .grant_o(grant)
  );

  assign req_o   = any_pend & ~wait_f;
  assign take    = ack_i & req_o;
  assign clr_vec = take ? grant : '0;

  irq_flag_keep #(
    .FW(FW), .I_BIT(I_BIT), .LOW_W(LOW_W), .SEQ_EN(SEQ_EN),
    .RTI_LOW_ONLY(RTI_LOW_ONLY), .I_AT_RESET(I_AT_RESET)
  ) u_flags (
    .clk_i, .rst_ni,
    .enter_i(take), .rti_i, .clri_i(clr_ibit_i),
    .wr_i(flag_wr_i), .wdata_i(flag_data_i),
    .flags_o, .wait_o(wait_f)
  );

  assign pend_o = pend;

  // I set for two sampled cycles means the wait flag has caught up
  p_seq_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SEQ_EN && flags_o[I_BIT] && $past(flags_o[I_BIT])) |-> !req_o);

  p_ack_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !rti_i && !clr_ibit_i && !flag_wr_i) |=>
      flags_o == $past(flags_o));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hw = '0, sw = '0, mask_d = '0, fdata = '0;
  logic       mask_wr = 1'b0, ack = 1'b0, rti = 1'b0, clri = 1'b0, fwr = 1'b0;

  logic       req_a, req_b;
  logic [2:0] vec_a, vec_b;
  logic [7:0] pend_a, pend_b, flags_a, flags_b;

  int n_chk = 0;
  int n_err = 0;
  logic [2:0] q_a[$];
  logic [2:0] q_b[$];

  always #2.5 clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_hw_i(hw), .irq_sw_i(sw),
    .mask_wr_i(mask_wr), .mask_data_i(mask_d), .ack_i(ack), .rti_i(rti),
    .clr_ibit_i(clri), .flag_wr_i(fwr), .flag_data_i(fdata),
    .req_o(req_a), .vec_o(vec_a), .pend_o(pend_a), .flags_o(flags_a)
  );

  irq_pend_ctrl #(.NMI_EN(1'b1), .SEQ_EN(1'b1), .RTI_LOW_ONLY(1'b1),
                  .I_AT_RESET(1'b1)) u_irq_pend_ctrl_opt (
    .clk_i(clk), .rst_ni(rst_n), .irq_hw_i(hw), .irq_sw_i(sw),
    .mask_wr_i(mask_wr), .mask_data_i(mask_d), .ack_i(ack), .rti_i(rti),
    .clr_ibit_i(clri), .flag_wr_i(fwr), .flag_data_i(fdata),
    .req_o(req_b), .vec_o(vec_b), .pend_o(pend_b), .flags_o(flags_b)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: an accepted acknowledge must match the queued vector
  always @(negedge clk) begin
    if (rst_n && ack && req_a) begin
      n_chk++;
      if (q_a.size() == 0) begin
        n_err++;
        $display("FAIL R3 default unexpected ack act=%0d exp=none", vec_a);
      end else begin
        logic [2:0] e;
        e = q_a.pop_front();
        if (vec_a !== e) begin
          n_err++;
          $display("FAIL R3 default vector act=%0d exp=%0d", vec_a, e);
        end
      end
    end
    if (rst_n && ack && req_b) begin
      n_chk++;
      if (q_b.size() == 0) begin
        n_err++;
        $display("FAIL R10 options unexpected ack act=%0d exp=none", vec_b);
      end else begin
        logic [2:0] e;
        e = q_b.pop_front();
        if (vec_b !== e) begin
          n_err++;
          $display("FAIL R9 options vector act=%0d exp=%0d", vec_b, e);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk("R11 pend a", pend_a, 8'h00);
    chk("R11 flags a", flags_a, 8'h00);
    chk("R11 req a", {7'd0, req_a}, 8'h00);
    chk("R11 pend b", pend_b, 8'h00);
    chk("R11 flags b", flags_b, 8'h08);

    // R1 mask is zero: source 0 dropped; R9 NMI passes in options build
    hw = 8'h01; tick(); hw = '0;
    chk("R1 masked src0 a", pend_a, 8'h00);
    chk("R9 nmi pend b", pend_b, 8'h01);
    tick();
    chk("R10 nmi blocked b", {7'd0, req_b}, 8'h00);

    // R1 mask load, masked lines dropped, sw and hw merged
    mask_wr = 1'b1; mask_d = 8'hF0; tick(); mask_wr = 1'b0;
    hw = 8'h0A; sw = 8'h20; tick(); hw = '0; sw = '0;
    chk("R1 pend a", pend_a, 8'h20);
    chk("R1 pend b", pend_b, 8'h21);
    chk("R3 req a", {7'd0, req_a}, 8'h01);
    chk("R3 vec a", {5'd0, vec_a}, 8'h05);

    hw = 8'h40; sw = 8'h80; tick(); hw = '0; sw = '0;
    chk("R2 pend a", pend_a, 8'hE0);
    chk("R3 prio vec a", {5'd0, vec_a}, 8'h05);
    chk("R2 pend b", pend_b, 8'hE1);

    // R8 flag load, clears I in options build
    fwr = 1'b1; fdata = 8'hF2; tick(); fwr = 1'b0;
    chk("R8 flags a", flags_a, 8'hF2);
    chk("R8 flags b", flags_b, 8'hF2);
    tick();
    chk("R10 release req b", {7'd0, req_b}, 8'h01);
    chk("R9 nmi wins vec b", {5'd0, vec_b}, 8'h00);

    // R4 R5 first acknowledge on both
    q_a.push_back(3'd5); q_b.push_back(3'd0);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 clear a", pend_a, 8'hC0);
    chk("R5 enter a", flags_a, 8'hFA);
    chk("R4 clear b", pend_b, 8'hE0);
    chk("R5 enter b", flags_b, 8'hFA);
    chk("R10 nest vec a", {5'd0, vec_a}, 8'h06);
    tick();
    chk("R10 seq blocks b", {7'd0, req_b}, 8'h00);
    chk("R10 nest req a", {7'd0, req_a}, 8'h01);

    // nested acknowledge on default build, ignored by options build
    q_a.push_back(3'd6);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 nested a", pend_a, 8'h80);
    chk("R4 ignored pend b", pend_b, 8'hE0);
    chk("R4 ignored flags b", flags_b, 8'hFA);

    // R6 ISR alters GP flags then returns
    fwr = 1'b1; fdata = 8'h5A; tick(); fwr = 1'b0;
    rti = 1'b1; tick(); rti = 1'b0;
    chk("R6 full restore a", flags_a, 8'hFA);
    chk("R6 partial restore b", flags_b, 8'h52);

    // R7 clear I only
    clri = 1'b1; tick(); clri = 1'b0;
    chk("R7 clear i a", flags_a, 8'hF2);
    chk("R7 clear i b", flags_b, 8'h52);
    tick();
    chk("R10 req b after rti", {7'd0, req_b}, 8'h01);
    chk("R3 vec b", {5'd0, vec_b}, 8'h05);

    q_a.push_back(3'd7); q_b.push_back(3'd5);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 empty a", pend_a, 8'h00);
    chk("R3 no req a", {7'd0, req_a}, 8'h00);
    chk("R4 clear b", pend_b, 8'hC0);
    chk("R5 enter flags b", flags_b, 8'h5A);
    tick();

    // R4 acknowledge with no request
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 no-req flags a", flags_a, 8'hFA);
    chk("R4 no-req pend a", pend_a, 8'h00);
    chk("R4 no-req pend b", pend_b, 8'hC0);

    // R2 new request on the acknowledged bit keeps it pending
    sw = 8'h10; tick();
    q_a.push_back(3'd4);
    ack = 1'b1; tick(); ack = 1'b0; sw = '0;
    chk("R2 set beats clear a", pend_a, 8'h10);
    chk("R2 pend b", pend_b, 8'hD0);
    tick();

    n_chk++;
    if (q_a.size() != 0 || q_b.size() != 0) begin
      n_err++;
      $display("FAIL R4 scoreboard act=%0d exp=0", q_a.size() + q_b.size());
    end
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule